// File: doc/BRIEF.md
# Swallow Counter Split Calculator

This block converts a total division ratio `n` for a dual-modulus prescaler PLL into the two counter values that the synthesizer loads. The main counter value is the whole-number part of `n` divided by the prescaler modulus M, and the swallow value is what is left over. One ratio is taken per handshake. The block then works through the ratio one bit per cycle with restoring division, or with a shift and a mask when M is a power of two, and presents both values with a one-cycle valid strobe.

The reference divider value, which is the oscillator frequency over the comparison frequency (a 12.8 MHz oscillator with a 12.5 kHz channel step gives 1024 by default), is a build-time constant. It is driven out unchanged next to the computed pair. A flag marks results that the two counters cannot hold: a main value too wide for its field, or a swallow value that is not smaller than the main value. Turning the values into serial words and choosing the channel plan are left to other logic.

Top module: `swallow_split`

## Requirements
- R1: When a result is strobed, `out_n` holds the low `N_W` bits of floor(n / MOD), where n is the ratio accepted for that result (default MOD = 64, so ratio 32615 gives 509 and ratio 32616 gives 509).
- R2: When a result is strobed, `out_a` holds n - MOD * floor(n / MOD), which is always below MOD (with MOD = 64, ratio 32615 gives 39 and ratio 32616 gives 40).
- R3: `out_r` always equals the parameter `REF_DIV`, truncated to `R_W` bits.
- R4: `out_valid` is high for exactly one cycle. It rises RATIO_W + 1 clock edges after the edge that accepted the ratio.
- R5: `in_ready` is low from the accepting edge until the strobe cycle. While it is low, `in_valid` is ignored: there is no extra strobe and the result still belongs to the first ratio.
- R6: `out_err` is 1 when floor(n / MOD) does not fit in `N_W` bits (it is 2^N_W or more).
- R7: `out_err` is 1 when the remainder is not less than the full quotient floor(n / MOD). It is 0 when neither this condition nor the one in R6 holds.
- R8: After reset, `in_ready` = 1, `out_valid` = 0, and `out_n`, `out_a`, `out_err` are 0.
- R9: `out_n`, `out_a` and `out_err` keep their values in every cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Ratio offered |
| in_ratio | input | RATIO_W | Total division ratio n |
| in_ready | output | 1 | Block idle; ratio taken when in_valid is also high |
| out_valid | output | 1 | One-cycle strobe for a new result |
| out_n | output | N_W | Main counter value |
| out_a | output | A_W | Swallow counter value |
| out_r | output | R_W | Reference divider constant |
| out_err | output | 1 | Result not loadable (field overflow or swallow not below main) |

## Verification
The bench builds two copies of the block. The first uses MOD = 64 with a 16-bit ratio, which selects the shift-and-mask path. Every ratio from 0 to 1023 is swept on it, together with the worked ratios near 32615 and the top of the range. The second uses MOD = 12 with a 9-bit ratio and a 5-bit main field. That choice selects the restoring-division path and makes the sweep of all 512 ratios exhaustive. The small main field also brings the overflow flag, the swallow-not-below-main flag and their boundaries within reach on that copy.

// File: rtl/swallow_pkg.sv
// Shared helpers for the swallow counter split calculator.
// Assumes: only constant arguments at elaboration time.
package swallow_pkg;

    // True when v is a nonzero power of two.
    function automatic bit is_pow2(input int unsigned v);
        return (v != 0) && ((v & (v - 1)) == 0);
    endfunction

endpackage

// File: rtl/swallow_div_engine.sv
// Divides a ratio by the constant MOD in a fixed RATIO_W cycles.
// For a power-of-two MOD it loads a shift-and-mask result and only counts
// the cycles; otherwise it runs a restoring step per cycle, MSB first.
// Assumes: MOD >= 2, RATIO_W >= DW, start only while not busy.
module swallow_div_engine #(
    parameter int RATIO_W = 18,
    parameter int MOD     = 64,
    localparam int DW     = $clog2(MOD) + 1,
    localparam int CW     = $clog2(RATIO_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [RATIO_W-1:0] ratio,
    output logic               done,
    output logic [RATIO_W-1:0] quot,
    output logic [DW-1:0]      rem
);
    localparam int SH = $clog2(MOD);

    logic               busy;
    logic [CW-1:0]      cnt;
    logic [RATIO_W-1:0] quo_q;
    logic [DW-1:0]      rem_q;

    // Step counter: RATIO_W busy cycles, then a one-cycle done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= busy && (cnt == CW'(RATIO_W - 1));
            if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                cnt <= cnt + 1'b1;
                if (cnt == CW'(RATIO_W - 1)) busy <= 1'b0;
            end
        end
    end

    generate
        if (swallow_pkg::is_pow2(MOD)) begin : g_shift
            // Power-of-two modulus: quotient and remainder loaded at start.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    quo_q <= '0;
                    rem_q <= '0;
                end else if (start) begin
                    quo_q <= ratio >> SH;
                    rem_q <= DW'(ratio & RATIO_W'(MOD - 1));
                end
            end
        end else begin : g_restore
            logic [DW-1:0] trial;
            logic          fits;
            // One restoring trial: bring in the next dividend bit.
            always_comb begin
                trial = {rem_q[DW-2:0], quo_q[RATIO_W-1]};
                fits  = trial >= DW'(MOD);
            end
            // Shift the quotient in and keep the restored remainder.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    quo_q <= '0;
                    rem_q <= '0;
                end else if (start) begin
                    quo_q <= ratio;
                    rem_q <= '0;
                end else if (busy) begin
                    quo_q <= {quo_q[RATIO_W-2:0], fits};
                    rem_q <= fits ? trial - DW'(MOD) : trial;
                end
            end
        end
    endgenerate

    assign quot = quo_q;
    assign rem  = rem_q;

    // R2: the running remainder never reaches the modulus.
    p_rem_below_mod_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rem_q < DW'(MOD));

    // R4: the done pulse lasts a single cycle.
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/swallow_field_check.sv
// Maps the full quotient and remainder onto the main and swallow fields
// and flags results the counters cannot load.
// Assumes: RATIO_W >= DW and A_W >= DW - 1 (remainder always fits).
module swallow_field_check #(
    parameter int RATIO_W = 18,
    parameter int DW      = 7,
    parameter int N_W     = 11,
    parameter int A_W     = 7
) (
    input  logic [RATIO_W-1:0] quot,
    input  logic [DW-1:0]      rem,
    output logic [N_W-1:0]     n_field,
    output logic [A_W-1:0]     a_field,
    output logic               err
);
    logic too_wide;
    logic swallow_big;

    // Range tests on the full-width values, then field truncation.
    always_comb begin
        too_wide    = |(quot >> N_W);
        swallow_big = RATIO_W'(rem) >= quot;
        err         = too_wide || swallow_big;
        n_field     = N_W'(quot);
        a_field     = A_W'(rem);
    end

endmodule

// File: rtl/swallow_split.sv
// Top: accepts a division ratio when idle, splits it into main and swallow
// counter values after RATIO_W + 1 cycles, and strobes the result.
// Assumes: MOD >= 2, MOD <= 2**A_W, N_W >= A_W, RATIO_W >= clog2(MOD) + 1.
module swallow_split #(
    parameter int RATIO_W = 18,
    parameter int MOD     = 64,
    parameter int N_W     = 11,
    parameter int A_W     = 7,
    parameter int R_W     = 14,
    parameter int REF_DIV = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [RATIO_W-1:0] in_ratio,
    output logic               in_ready,
    output logic               out_valid,
    output logic [N_W-1:0]     out_n,
    output logic [A_W-1:0]     out_a,
    output logic [R_W-1:0]     out_r,
    output logic               out_err
);
    localparam int DW  = $clog2(MOD) + 1;
    localparam int LCW = $clog2(RATIO_W + 2);

    logic               busy_q;
    logic               accept;
    logic               eng_done;
    logic [RATIO_W-1:0] eng_quot;
    logic [DW-1:0]      eng_rem;
    logic [N_W-1:0]     n_next;
    logic [A_W-1:0]     a_next;
    logic               err_next;
    logic [LCW-1:0]     lat_cnt;

    assign in_ready = !busy_q;
    assign accept   = in_valid && !busy_q;
    assign out_r    = R_W'(REF_DIV);

    swallow_div_engine #(.RATIO_W(RATIO_W), .MOD(MOD)) u_engine (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .ratio (in_ratio),
        .done  (eng_done),
        .quot  (eng_quot),
        .rem   (eng_rem)
    );

    swallow_field_check #(.RATIO_W(RATIO_W), .DW(DW), .N_W(N_W), .A_W(A_W)) u_check (
        .quot    (eng_quot),
        .rem     (eng_rem),
        .n_field (n_next),
        .a_field (a_next),
        .err     (err_next)
    );

    // Busy tracking and result register; strobe when the engine finishes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            out_valid <= 1'b0;
            out_n     <= '0;
            out_a     <= '0;
            out_err   <= 1'b0;
        end else begin
            out_valid <= eng_done;
            if (accept) busy_q <= 1'b1;
            if (eng_done) begin
                busy_q  <= 1'b0;
                out_n   <= n_next;
                out_a   <= a_next;
                out_err <= err_next;
            end
        end
    end

    // Cycles since acceptance, used by the latency property.
    always_ff @(posedge clk) begin
        if (!rst_n)      lat_cnt <= '0;
        else if (accept) lat_cnt <= '0;
        else if (busy_q) lat_cnt <= lat_cnt + 1'b1;
    end

    // R5: taking a ratio closes the input the next cycle.
    p_busy_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R4: single-cycle strobe.
    p_single_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    // R4: strobe lands RATIO_W + 1 edges after acceptance.
    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (lat_cnt == LCW'(RATIO_W + 1)));

    // R9: result fields hold between strobes.
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> ($stable(out_n) && $stable(out_a) && $stable(out_err)));

    // R7: a result without the flag has the swallow value below the main value.
    p_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_err) |-> (N_W'(out_a) < out_n));

endmodule

// File: tb/swallow_split_bench.sv
module swallow_split_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    // Copy A: MOD 64, 16-bit ratio (shift path).
    logic        iv_a = 1'b0;
    logic [15:0] ir_a = '0;
    logic        rdy_a, ov_a, err_a;
    logic [10:0] n_a;
    logic [6:0]  a_a;
    logic [13:0] r_a;

    // Copy B: MOD 12, 9-bit ratio, 5-bit main field (restoring path).
    logic        iv_b = 1'b0;
    logic [8:0]  ir_b = '0;
    logic        rdy_b, ov_b, err_b;
    logic [4:0]  n_b;
    logic [3:0]  a_b;
    logic [7:0]  r_b;

    swallow_split #(.RATIO_W(16), .MOD(64), .N_W(11), .A_W(7), .R_W(14), .REF_DIV(1024)) u_swallow_split (
        .clk(clk), .rst_n(rst_n), .in_valid(iv_a), .in_ratio(ir_a), .in_ready(rdy_a),
        .out_valid(ov_a), .out_n(n_a), .out_a(a_a), .out_r(r_a), .out_err(err_a));

    swallow_split #(.RATIO_W(9), .MOD(12), .N_W(5), .A_W(4), .R_W(8), .REF_DIV(37)) u_swallow_split_b (
        .clk(clk), .rst_n(rst_n), .in_valid(iv_b), .in_ratio(ir_b), .in_ready(rdy_b),
        .out_valid(ov_b), .out_n(n_b), .out_a(a_b), .out_r(r_b), .out_err(err_b));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    function automatic bit sv_valid(input int sel); return sel ? ov_b : ov_a; endfunction
    function automatic bit sv_ready(input int sel); return sel ? rdy_b : rdy_a; endfunction

    // One transaction on copy sel; optional extra in_valid pulses while busy.
    task automatic run(input int sel, input int n, input bit noisy);
        int w, m, nw, q, r, cnt, on, oa, oe;
        bit ovf, eerr;
        w  = sel ? 9 : 16;
        m  = sel ? 12 : 64;
        nw = sel ? 5 : 11;
        while (!sv_ready(sel)) @(negedge clk);
        if (sel) begin iv_b = 1'b1; ir_b = 9'(n); end
        else     begin iv_a = 1'b1; ir_a = 16'(n); end
        @(negedge clk);
        cnt = 0;
        if (noisy) begin
            if (sel) ir_b = 9'(n ^ 5); else ir_a = 16'(n ^ 5);
        end else begin
            iv_a = 1'b0; iv_b = 1'b0;
        end
        check(!sv_ready(sel), "R5 ready low after accept", int'(sv_ready(sel)), 0);
        while (!sv_valid(sel) && cnt < 100) begin
            @(negedge clk);
            cnt++;
            if (cnt >= 2) begin iv_a = 1'b0; iv_b = 1'b0; end
        end
        q = n / m;
        r = n % m;
        ovf  = q >= (1 << nw);
        eerr = ovf || (r >= q);
        on = sel ? int'(n_b) : int'(n_a);
        oa = sel ? int'(a_b) : int'(a_a);
        oe = sel ? int'(err_b) : int'(err_a);
        check(cnt == w + 1, "R4 latency", cnt, w + 1);
        check(on == (q & ((1 << nw) - 1)), "R1 main value", on, q & ((1 << nw) - 1));
        check(oa == r, "R2 swallow value", oa, r);
        check(oe == int'(eerr), ovf ? "R6 overflow flag" : "R7 order flag", oe, int'(eerr));
        check(sv_ready(sel), "R5 ready at strobe", int'(sv_ready(sel)), 1);
        @(negedge clk);
        check(!sv_valid(sel), "R4 single strobe", int'(sv_valid(sel)), 0);
        if (noisy) begin
            check((sel ? int'(n_b) : int'(n_a)) == on, "R5 noise ignored", sel ? int'(n_b) : int'(n_a), on);
        end
        // R9: fields stay put without a strobe.
        check((sel ? int'(a_b) : int'(a_a)) == oa, "R9 hold swallow", sel ? int'(a_b) : int'(a_a), oa);
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=0 expected=1");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8: reset state on both copies.
        check(rdy_a && rdy_b, "R8 ready after reset", int'(rdy_a && rdy_b), 1);
        check(!ov_a && !ov_b, "R8 no strobe after reset", int'(ov_a || ov_b), 0);
        check(n_a == 0 && a_a == 0 && !err_a, "R8 fields zero", int'(n_a) + int'(a_a), 0);
        check(n_b == 0 && a_b == 0 && !err_b, "R8 fields zero copy b", int'(n_b) + int'(a_b), 0);
        // R3: reference divider constant.
        check(r_a == 14'd1024, "R3 reference value", int'(r_a), 1024);
        check(r_b == 8'd37, "R3 reference value copy b", int'(r_b), 37);

        // Worked ratios and range top on copy A.
        run(0, 32615, 1'b0);
        check(n_a == 11'd509 && a_a == 7'd39, "R1 R2 ratio 32615", int'(n_a) * 1000 + int'(a_a), 509039);
        run(0, 32616, 1'b0);
        check(n_a == 11'd509 && a_a == 7'd40, "R1 R2 ratio 32616", int'(n_a) * 1000 + int'(a_a), 509040);
        run(0, 65535, 1'b0);
        run(0, 32640, 1'b1);
        for (int i = 0; i < 1024; i++) run(0, i, 1'b0);

        // Exhaustive on copy B, with busy-time noise on every eighth ratio.
        for (int i = 0; i < 512; i++) run(1, i, (i % 8) == 3);

        // R3: constant unchanged after traffic.
        check(r_a == 14'd1024 && r_b == 8'd37, "R3 reference stable", int'(r_a), 1024);
        summary();
    end
endmodule